// File: doc/BRIEF.md
# Carry and Condition Flag Unit

This unit computes the fixed-point operations whose side effects are the carry bit and the condition register. From two operands, a carry-in, an operation code, a field index, the summary-overflow and carry bits of the fixed-point status register and a 32/64-bit mode flag, it produces a result, a new carry bit and an updated 32-bit condition register. Add-with-carry covers plain and extended add and subtract-from. Signed and unsigned compares write one 4-bit condition field. Two algebraic right shifts set carry when a negative value loses one bits. A record flag also writes the top condition field from the sign of the result.

All outputs are registered: an operation presented with `in_valid` high appears one clock later with `out_valid` high. When `in_valid` is low, the outputs hold their last values. The caller supplies the current condition register on `cr_in` and keeps the returned value.

Top module: `carry_flag_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result`, `ca_out`, `cr_out` and `out_valid` become zero.
- R2: Add-type codes give `result` = X + B + C (modulo 2^64). Code 0 uses X=A, C=`carry_in`. Code 1 uses X=A, C=`xer_ca`. Code 2 uses X=~A, C=1. Code 3 uses X=~A, C=`xer_ca`.
- R3: For codes 0..3, `ca_out` is 1 exactly when the sum is below X, or when C=1 and the sum equals X. With `mode64`=0, this comparison uses only bits 31:0 of both values.
- R4: With `record`=1 on codes 0..3, 8 and 9, `cr_out[31:28]` = {LT,GT,EQ,SO}. These bits give the sign of the result (sign-extended from bit 31 when `mode64`=0) and SO = `xer_so`. All other bits come from `cr_in`. With `record`=0 on these codes, `cr_out` = `cr_in`.
- R5: Compare codes 4 (signed) and 5 (unsigned) compare A with B over 64 bits. They write {LT,GT,EQ,SO} (LT as the field's most significant bit, SO = `xer_so`) into `cr_out` bits [(7-n)*4+3 : (7-n)*4], where n = `crf_sel`. Other bits come from `cr_in`, `ca_out` = `xer_ca` and `result` = 0. `record` has no effect.
- R6: Word compare codes 6 (signed) and 7 (unsigned) reduce both operands to bits 31:0 before comparing. Code 6 sign-extends them and code 7 zero-extends them. Placement is as in R5.
- R7: Code 8 (word algebraic shift) sign-extends A[31:0] and shifts it right by B[5:0]. Amounts of 32 or more shift by 31.
- R8: For codes 8 and 9, `ca_out` = 1 only when the shifted source is negative and either the amount saturated or at least one 1 bit was shifted out. Otherwise `ca_out` is 0.
- R9: Code 9 (doubleword algebraic shift) shifts A right by B[6:0], and amounts of 64 or more shift by 63.
- R10: With `in_valid` low at a clock edge, `result`, `ca_out` and `cr_out` keep their values whatever the other inputs do.
- R11: `out_valid` equals `in_valid` from the previous clock edge.
- R12: Codes 10..15 give `result` = 0, `ca_out` = `xer_ca` and `cr_out` = `cr_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (0..9, see requirements) |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand or shift amount |
| carry_in | input | 1 | Carry-in for code 0 |
| record | input | 1 | Also update the top condition field |
| crf_sel | input | 3 | Condition field index for compares |
| xer_so | input | 1 | Current summary-overflow bit |
| xer_ca | input | 1 | Current carry bit |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| cr_in | input | 32 | Current condition register |
| out_valid | output | 1 | Registered outputs hold a new result |
| result | output | 64 | Operation result |
| ca_out | output | 1 | New carry bit |
| cr_out | output | 32 | Updated condition register |

## Verification
Every output is registered directly from one cycle of inputs, so a wrong carry tap, a wrong field position or a wrong sign test shows on `ca_out` or `cr_out` in the cycle after the operation. Nothing is hidden to surface later. The corner cases that matter are the 32-bit carry boundary (0xFFFFFFFF + 1), word compares whose upper halves differ, and shift amounts at and beyond saturation with and without lost one bits. The bench drives these directly and mixes them with random traffic against a reference model.

// File: rtl/cfu_pkg.sv
// Shared operation codes for the carry and condition flag unit.
// Assumes a 4-bit operation field; codes above 9 are reserved.
package cfu_pkg;
    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDX  = 4'd1,
        OP_SUBF  = 4'd2,
        OP_SUBFX = 4'd3,
        OP_CMPS  = 4'd4,
        OP_CMPU  = 4'd5,
        OP_CMPSW = 4'd6,
        OP_CMPUW = 4'd7,
        OP_SRAW  = 4'd8,
        OP_SRAD  = 4'd9
    } cfu_op_e;

    localparam int CR_W      = 32;
    localparam int CR_FIELDS = 8;
    localparam int NIB_W     = CR_W / CR_FIELDS;
endpackage

// File: rtl/cfu_adder.sv
// Add-with-carry with two carry taps: the full-width carry and the
// carry out of the low half. The mode flag selects which one is reported.
// Assumes XLEN is even.
module cfu_adder #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] x,
    input  logic [XLEN-1:0] y,
    input  logic            cin,
    input  logic            mode64,
    output logic [XLEN-1:0] sum,
    output logic            cout
);
    localparam int HALF = XLEN / 2;

    logic [XLEN:0] full_sum;
    logic [HALF:0] low_sum;

    // Full-width sum with its carry.
    always_comb begin
        full_sum = {1'b0, x} + {1'b0, y} + {{XLEN{1'b0}}, cin};
    end

    // Low-half sum, used only for its carry in 32-bit mode.
    always_comb begin
        low_sum = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + {{HALF{1'b0}}, cin};
    end

    // Result and mode-dependent carry tap.
    always_comb begin
        sum  = full_sum[XLEN-1:0];
        cout = mode64 ? full_sum[XLEN] : low_sum[HALF];
    end
endmodule

// File: rtl/cfu_cmp.sv
// Three-way compare that forms a {LT,GT,EQ,SO} nibble. In word mode it
// reduces both operands to the low half first (sign- or zero-extended).
// Also used against zero for the record-form sign test.
module cfu_cmp #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] x,
    input  logic [XLEN-1:0] y,
    input  logic            is_signed,
    input  logic            word,
    input  logic            so,
    output logic [3:0]      nib
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] xr;
    logic [XLEN-1:0] yr;
    logic            lt;
    logic            gt;
    logic            eq;

    // Operand reduction for word compares.
    always_comb begin
        xr = x;
        yr = y;
        if (word) begin
            if (is_signed) begin
                xr = {{HALF{x[HALF-1]}}, x[HALF-1:0]};
                yr = {{HALF{y[HALF-1]}}, y[HALF-1:0]};
            end else begin
                xr = {{HALF{1'b0}}, x[HALF-1:0]};
                yr = {{HALF{1'b0}}, y[HALF-1:0]};
            end
        end
    end

    // Independent less, greater and equal decisions.
    always_comb begin
        lt  = is_signed ? ($signed(xr) < $signed(yr)) : (xr < yr);
        gt  = is_signed ? ($signed(xr) > $signed(yr)) : (xr > yr);
        eq  = (xr == yr);
        nib = {lt, gt, eq, so};
    end

    // R5: exactly one of LT, GT, EQ is set.
    always_comb begin
        one_flag_chk: assert ($countones({lt, gt, eq}) == 1);
    end
endmodule

// File: rtl/cfu_sra.sv
// Algebraic right shift with saturating amount and lost-ones carry.
// Word mode sign-extends the low half and saturates at HALF-1; otherwise
// the shift saturates at XLEN-1. Assumes XLEN is a power of two.
module cfu_sra #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] amt_reg,
    input  logic            word,
    output logic [XLEN-1:0] res,
    output logic            ca
);
    localparam int HALF = XLEN / 2;
    localparam int AW   = $clog2(XLEN) + 1;

    logic [XLEN-1:0] s;
    logic [AW-1:0]   amt;
    logic [AW-1:0]   lim;
    logic            big;
    logic [AW-2:0]   sh;
    logic            lost;

    // Source and amount selection by width.
    always_comb begin
        if (word) begin
            s   = {{HALF{src[HALF-1]}}, src[HALF-1:0]};
            amt = {1'b0, amt_reg[AW-2:0]};
            lim = AW'(HALF);
        end else begin
            s   = src;
            amt = amt_reg[AW-1:0];
            lim = AW'(XLEN);
        end
    end

    // Saturated shift count and shifted value.
    always_comb begin
        big = (amt >= lim);
        sh  = big ? (AW-1)'(lim - 1'b1) : amt[AW-2:0];
        res = XLEN'($signed(s) >>> sh);
    end

    // Carry: negative source that saturated or dropped a one bit.
    always_comb begin
        lost = |(s & ~({XLEN{1'b1}} << sh));
        ca   = s[XLEN-1] & (big | lost);
    end

    // R8: a set carry only comes with a negative result.
    always_comb begin
        sra_ca_sign_chk: assert (!ca || res[XLEN-1]);
    end
endmodule

// File: rtl/carry_flag_unit.sv
// Carry and condition flag unit. It selects add, compare or shift per
// operation code, forms the carry bit and the updated condition register,
// and registers everything one cycle after in_valid. Assumes the caller
// returns cr_out and the carry to its own state. Reset is synchronous,
// active low.
module carry_flag_unit #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic            carry_in,
    input  logic            record,
    input  logic [2:0]      crf_sel,
    input  logic            xer_so,
    input  logic            xer_ca,
    input  logic            mode64,
    input  logic [31:0]     cr_in,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            ca_out,
    output logic [31:0]     cr_out
);
    import cfu_pkg::*;

    cfu_op_e         op_e;
    logic            is_add;
    logic            is_cmp;
    logic            is_sra;
    logic [XLEN-1:0] add_x;
    logic            add_cin;
    logic [XLEN-1:0] add_sum;
    logic            add_cout;
    logic            cmp_signed;
    logic            cmp_word;
    logic [3:0]      cmp_nib;
    logic [XLEN-1:0] sra_res;
    logic            sra_ca;
    logic [XLEN-1:0] res_next;
    logic            ca_next;
    logic [3:0]      rec_nib;
    logic [31:0]     cr_next;
    logic [4:0]      fld_base;

    // Operation class decode.
    always_comb begin
        op_e       = cfu_op_e'(op);
        is_add     = (op <= 4'd3);
        is_cmp     = (op >= 4'd4) && (op <= 4'd7);
        is_sra     = (op == 4'd8) || (op == 4'd9);
        cmp_signed = (op_e == OP_CMPS) || (op_e == OP_CMPSW);
        cmp_word   = (op_e == OP_CMPSW) || (op_e == OP_CMPUW);
    end

    // Adder operand inversion and carry-in source.
    always_comb begin
        add_x   = (op_e == OP_SUBF || op_e == OP_SUBFX) ? ~opnd_a : opnd_a;
        unique case (op_e)
            OP_ADD:  add_cin = carry_in;
            OP_SUBF: add_cin = 1'b1;
            default: add_cin = xer_ca;
        endcase
    end

    cfu_adder #(.XLEN(XLEN)) u_add (
        .x      (add_x),
        .y      (opnd_b),
        .cin    (add_cin),
        .mode64 (mode64),
        .sum    (add_sum),
        .cout   (add_cout)
    );

    cfu_cmp #(.XLEN(XLEN)) u_cmp (
        .x         (opnd_a),
        .y         (opnd_b),
        .is_signed (cmp_signed),
        .word      (cmp_word),
        .so        (xer_so),
        .nib       (cmp_nib)
    );

    cfu_sra #(.XLEN(XLEN)) u_sra (
        .src     (opnd_a),
        .amt_reg (opnd_b),
        .word    (op_e == OP_SRAW),
        .res     (sra_res),
        .ca      (sra_ca)
    );

    // Result and carry selection per class.
    always_comb begin
        if (is_add) begin
            res_next = add_sum;
            ca_next  = add_cout;
        end else if (is_sra) begin
            res_next = sra_res;
            ca_next  = sra_ca;
        end else begin
            res_next = '0;
            ca_next  = xer_ca;
        end
    end

    // Record-form sign test of the selected result against zero.
    cfu_cmp #(.XLEN(XLEN)) u_rec (
        .x         (res_next),
        .y         ('0),
        .is_signed (1'b1),
        .word      (~mode64),
        .so        (xer_so),
        .nib       (rec_nib)
    );

    // Condition register update: compare field or top field.
    always_comb begin
        fld_base = {~crf_sel, 2'b00};
        cr_next  = cr_in;
        if (is_cmp) begin
            cr_next[fld_base +: NIB_W] = cmp_nib;
        end else if ((is_add || is_sra) && record) begin
            cr_next[CR_W-1 -: NIB_W] = rec_nib;
        end
    end

    // Output registers, loaded only for valid operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ca_out    <= 1'b0;
            cr_out    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_next;
                ca_out <= ca_next;
                cr_out <= cr_next;
            end
        end
    end

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |->
            ($stable(result) && $stable(ca_out) && $stable(cr_out)));

    // R5
    cmp_ca_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) >= 4'd4 && $past(op) <= 4'd7) |->
            (ca_out == $past(xer_ca)));

    // R4
    no_rec_cr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(record) && ($past(op) <= 4'd3 || $past(op) == 4'd8 || $past(op) == 4'd9)) |->
            (cr_out == $past(cr_in)));
endmodule

// File: tb/sim_carry_flag_unit.sv
module sim_carry_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        carry_in = 1'b0;
    logic        record = 1'b0;
    logic [2:0]  crf_sel = '0;
    logic        xer_so = 1'b0;
    logic        xer_ca = 1'b0;
    logic        mode64 = 1'b1;
    logic [31:0] cr_in = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        ca_out;
    logic [31:0] cr_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    carry_flag_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
        .record(record), .crf_sel(crf_sel), .xer_so(xer_so),
        .xer_ca(xer_ca), .mode64(mode64), .cr_in(cr_in),
        .out_valid(out_valid), .result(result), .ca_out(ca_out),
        .cr_out(cr_out)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] sign_nib(input logic [63:0] v, input logic m64, input logic so);
        logic [63:0] w;
        w = m64 ? v : {{32{v[31]}}, v[31:0]};
        return {$signed(w) < 0, $signed(w) > 0, w == 64'd0, so};
    endfunction

    function automatic string tag_of(input logic [3:0] o);
        if (o <= 4'd3) return "R2,R3,R4";
        if (o == 4'd4 || o == 4'd5) return "R5";
        if (o == 4'd6 || o == 4'd7) return "R6";
        if (o == 4'd8) return "R7,R8,R4";
        if (o == 4'd9) return "R9,R8,R4";
        return "R12";
    endfunction

    // Reference model written from the requirements.
    task automatic model(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                         input logic ci, input logic rec, input logic [2:0] sel,
                         input logic so, input logic cai, input logic m64, input logic [31:0] cri,
                         output logic [63:0] r, output logic c, output logic [31:0] cr);
        logic [63:0] aa, x, y, iv;
        logic        cc, lt, gt;
        int          sh, fb;
        r = '0; c = cai; cr = cri;
        if (o <= 4'd3) begin
            aa = (o >= 4'd2) ? ~a : a;
            cc = (o == 4'd0) ? ci : (o == 4'd2) ? 1'b1 : cai;
            r  = aa + b + {63'd0, cc};
            if (m64) c = (r < aa) || (cc && r == aa);
            else     c = (r[31:0] < aa[31:0]) || (cc && r[31:0] == aa[31:0]);
            if (rec) cr[31:28] = sign_nib(r, m64, so);
        end else if (o <= 4'd7) begin
            x = a; y = b;
            if (o == 4'd6) begin x = {{32{a[31]}}, a[31:0]}; y = {{32{b[31]}}, b[31:0]}; end
            if (o == 4'd7) begin x = {32'd0, a[31:0]}; y = {32'd0, b[31:0]}; end
            if (o == 4'd4 || o == 4'd6) begin lt = $signed(x) < $signed(y); gt = $signed(x) > $signed(y); end
            else begin lt = x < y; gt = x > y; end
            fb = (7 - int'(sel)) * 4;
            cr = (cri & ~(32'hF << fb)) | ({28'd0, lt, gt, x == y, so} << fb);
        end else if (o <= 4'd9) begin
            if (o == 4'd8) begin
                iv = {{32{a[31]}}, a[31:0]};
                sh = int'(b[5:0]);
                r  = $signed(iv) >>> (sh < 32 ? sh : 31);
                c  = iv[63] && (sh >= 32 || (iv & ((64'd1 << sh) - 1)) != 0);
            end else begin
                iv = a;
                sh = int'(b[6:0]);
                r  = $signed(iv) >>> (sh < 64 ? sh : 63);
                c  = iv[63] && (sh >= 64 || ((iv & ((64'd1 << (sh & 63)) - 1)) != 0));
            end
            if (rec) cr[31:28] = sign_nib(r, m64, so);
        end
    endtask

    task automatic run_op(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                          input logic ci, input logic rec, input logic [2:0] sel,
                          input logic so, input logic cai, input logic m64, input logic [31:0] cri);
        logic [63:0] er;
        logic        ec;
        logic [31:0] ecr;
        @(negedge clk);
        op = o; opnd_a = a; opnd_b = b; carry_in = ci; record = rec; crf_sel = sel;
        xer_so = so; xer_ca = cai; mode64 = m64; cr_in = cri; in_valid = 1'b1;
        model(o, a, b, ci, rec, sel, so, cai, m64, cri, er, ec, ecr);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag_of(o), " result"}, result, er);
        check({tag_of(o), " carry"}, {63'd0, ca_out}, {63'd0, ec});
        check({tag_of(o), " cr"}, {32'd0, cr_out}, {32'd0, ecr});
        check("R11 out_valid", {63'd0, out_valid}, 64'd1);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] hr;
        logic        hc;
        logic [31:0] hcr;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 result", result, 64'd0);
        check("R1 carry", {63'd0, ca_out}, 64'd0);
        check("R1 cr", {32'd0, cr_out}, 64'd0);
        check("R1 out_valid", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;

        // R3: low-half carry boundary in both modes
        run_op(4'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 32'h1234_5678);
        run_op(4'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 32'h1234_5678);
        // R2: subtract-from equal operands carries
        run_op(4'd2, 64'd5, 64'd5, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 32'h0);
        run_op(4'd3, 64'd5, 64'd5, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF);
        run_op(4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 1'b1, 32'h0);
        // R5, R6: field placement and word reduction
        for (int n = 0; n < 8; n++)
            run_op(4'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 1'b1, 3'(n), 1'b1, 1'b1, 1'b1, 32'hA5A5_A5A5);
        run_op(4'd7, 64'h0000_0001_0000_0000, 64'd0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 32'h0);
        run_op(4'd6, 64'h0000_0000_8000_0000, 64'd1, 1'b0, 1'b0, 3'd7, 1'b0, 1'b0, 1'b1, 32'h0);
        run_op(4'd5, 64'h8000_0000_0000_0000, 64'd1, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 32'h0);
        // R7, R8, R9: saturation and lost ones
        run_op(4'd8, 64'h0000_0000_8000_0000, 64'd40, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0);
        run_op(4'd8, 64'h0000_0000_FFFF_FFFC, 64'd1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 32'h0);
        run_op(4'd8, 64'h0000_0000_FFFF_FFFD, 64'd1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 32'h0);
        run_op(4'd8, 64'h0000_0000_7FFF_FFFF, 64'd63, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 32'h0);
        run_op(4'd9, 64'h8000_0000_0000_0000, 64'd64, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 32'h0);
        run_op(4'd9, 64'hFFFF_FFFF_FFFF_FF00, 64'd8, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 32'h0);
        run_op(4'd9, 64'h4000_0000_0000_0000, 64'd127, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 32'h0);
        // R12: reserved code
        run_op(4'd12, 64'd7, 64'd9, 1'b1, 1'b1, 3'd1, 1'b1, 1'b1, 1'b1, 32'hDEAD_BEEF);

        // R10: inputs change with in_valid low, outputs hold
        hr = result; hc = ca_out; hcr = cr_out;
        @(negedge clk);
        op = 4'd0; opnd_a = 64'd123; opnd_b = 64'd456; cr_in = 32'h0F0F_0F0F; xer_ca = ~hc;
        @(posedge clk);
        @(negedge clk);
        check("R10 result", result, hr);
        check("R10 carry", {63'd0, ca_out}, {63'd0, hc});
        check("R10 cr", {32'd0, cr_out}, {32'd0, hcr});
        check("R11 idle", {63'd0, out_valid}, 64'd0);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] ra, rb;
            logic [3:0]  ro;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            ro = 4'($urandom % 11);
            if (ro == 4'd10) ro = 4'($urandom % 16);
            if ((ro == 4'd8 || ro == 4'd9) && ($urandom % 2 == 0)) rb = 64'($urandom % 80);
            if ($urandom % 8 == 0) rb = ra;
            run_op(ro, ra, rb, 1'($urandom), 1'($urandom), 3'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), $urandom);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule